// File: doc/BRIEF.md
# Multi-Rail Soft-Start Sequencer

This block orders the start-up of four regulated rails from comparator-style status flags. Two soft-start ramps are modelled: ramp A governs rails 2 and 4, and ramp B governs rails 1 and 3. Each ramp is a counter with a terminal count supplied at a port. A ramp's "charged" (up) flag rises once its counter reaches that count.

Rail 4's enable is raised straight after reset and does not depend on the supply power-on-reset flag. Ramp A starts once power-on-reset is reported. Ramp B is released once rail 2 reports power-good. A termination-good output latches on the first PHASE1 pulse after ramp B is released, and holds only while rail 2 stays above its minimum level. An overall power-good output reports that all four rails are in range.

An external fault counter can stop the sequence with an inhibit request. Ramp A can also be forced low from outside. In both cases rails 1 to 3 are inhibited, both ramps discharge, and the sequence restarts from ramp A once the condition clears. Rail 4 stays enabled throughout.

The state machine has four states:
- SEQ_IDLE: waiting for power-on-reset.
- SEQ_RAMP_A: ramp A charging, waiting for rail 2 power-good.
- SEQ_RAMP_B: both ramps released.
- SEQ_HOLD: stopped by inhibit or by the forced-low input.

Its transitions:
- IDLE→RAMP_A: POR good and no stop condition.
- RAMP_A→RAMP_B: rail 2 power-good.
- RAMP_A or RAMP_B→HOLD: inhibit or forced-low.
- HOLD→RAMP_A: both clear.
- Any state→IDLE: POR lost.

Top module: `rail_seq_top`

## Requirements
- R1: `rail4_en` is 0 while reset is held, becomes 1 at the first clock edge after reset and then stays 1 whatever POR, inhibit or forced-low do.
- R2: `ramp_a_en` rises on the clock edge that samples `por_ok`=1 with `inhibit_req`=0 and `ramp_a_force_low`=0 in SEQ_IDLE or SEQ_HOLD; it is 0 in any cycle where `por_ok` is 0.
- R3: `ramp_b_en` rises only on the clock edge after `rail_pg[1]` (rail 2 power-good) is sampled 1 while ramp A runs, and is never 1 without `ramp_a_en`.
- R4: a ramp's up flag is 1 exactly when its enable is 1 and the enable has been 1 for at least as many clock edges as the ramp's length input; the counter restarts from zero whenever the enable is 0.
- R5: `term_good` rises on the clock edge after a cycle with `phase1_pulse`=1, `ramp_b_en`=1 and `rail2_above_min`=1; pulses while ramp B is not released are ignored.
- R6: `term_good` falls in the same cycle as `rail2_above_min` falls and needs a new PHASE1 pulse to return.
- R7: `pgood` is 1 exactly when `ramp_b_en` is 1 and all four bits of `rail_pg` are 1 (bit i is rail i+1).
- R8: `ramp_a_force_low`=1 drops `ramp_a_en`, `ramp_b_en`, `term_good` and `pgood` and raises `rails123_inhibit` in the same cycle; after release the sequence restarts with ramp A from a zero count.
- R9: `inhibit_req`=1 has the same same-cycle effect as R8, with the same restart.
- R10: `por_ok`=0 returns the sequencer to SEQ_IDLE, with every output 0 except `rail4_en` (and `rails123_inhibit`=1).
- R11: `rails123_inhibit` is the complement of `ramp_a_en` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| por_ok | input | 1 | all supplies above power-on-reset thresholds |
| rail_pg | input | 4 | rail power-good flags, bit i = rail i+1 |
| rail2_above_min | input | 1 | rail 2 above its minimum level |
| phase1_pulse | input | 1 | PHASE1 pulse event |
| ramp_a_force_low | input | 1 | ramp A held low externally |
| inhibit_req | input | 1 | stop request from the fault counter |
| ramp_a_len | input | RAMP_W | ramp A terminal count |
| ramp_b_len | input | RAMP_W | ramp B terminal count |
| rail4_en | output | 1 | rail 4 controller enable |
| ramp_a_en | output | 1 | ramp A charge enable |
| ramp_b_en | output | 1 | ramp B charge enable |
| ramp_a_up | output | 1 | ramp A fully charged |
| ramp_b_up | output | 1 | ramp B fully charged |
| rails123_inhibit | output | 1 | inhibit for rails 1 to 3 |
| term_good | output | 1 | termination-good |
| pgood | output | 1 | all rails good |

## Verification
The assertions rely on the status inputs being driven to known values from time zero and changing only between clock edges. They also rely on `phase1_pulse` being the only event that can raise termination-good. The stimulus meets this by driving every input at the falling edge from a fixed-seed random source. The stop conditions are biased to be rare, so that full bring-ups occur often while POR loss, forced-low and inhibit still land in every state. Ramp lengths are kept small and sometimes zero so that the up flags are reached and the zero-length case is covered.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_RAMP_A = 2'd1,
        SEQ_RAMP_B = 2'd2,
        SEQ_HOLD   = 2'd3
    } seq_state_t;

    localparam int NUM_RAILS = 4;
    localparam int NUM_RAMPS = 2;
endpackage

// File: rtl/ss_ramp.sv
module ss_ramp #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] len,
    output logic             up
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!en)
            cnt_q <= '0;
        else if (cnt_q < len)
            cnt_q <= cnt_q + 1'b1;
    end

    always_comb up = en && (cnt_q >= len);

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt_q == '0));
    assert_up_needs_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up) |-> en);
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import rail_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 por_ok,
    input  logic [NUM_RAILS-1:0] rail_pg,
    input  logic                 rail2_above_min,
    input  logic                 phase1_pulse,
    input  logic                 ramp_a_force_low,
    input  logic                 inhibit_req,
    output logic                 ramp_a_en,
    output logic                 ramp_b_en,
    output logic                 rails123_inhibit,
    output logic                 term_good,
    output logic                 pgood
);
    seq_state_t state_q, state_d;
    logic       tg_q, tg_d;
    logic       stop;

    always_comb stop = inhibit_req || ramp_a_force_low || !por_ok;

    always_comb begin
        state_d = state_q;
        if (!por_ok) begin
            state_d = SEQ_IDLE;
        end else if (inhibit_req || ramp_a_force_low) begin
            state_d = (state_q == SEQ_IDLE) ? SEQ_IDLE : SEQ_HOLD;
        end else begin
            unique case (state_q)
                SEQ_IDLE:   state_d = SEQ_RAMP_A;
                SEQ_HOLD:   state_d = SEQ_RAMP_A;
                SEQ_RAMP_A: state_d = rail_pg[1] ? SEQ_RAMP_B : SEQ_RAMP_A;
                SEQ_RAMP_B: state_d = SEQ_RAMP_B;
                default:    state_d = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            tg_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            tg_q    <= tg_d;
        end
    end

    always_comb begin
        ramp_a_en        = ((state_q == SEQ_RAMP_A) || (state_q == SEQ_RAMP_B)) && !stop;
        ramp_b_en        = (state_q == SEQ_RAMP_B) && !stop;
        rails123_inhibit = !ramp_a_en;
        tg_d             = ramp_b_en && rail2_above_min && (tg_q || phase1_pulse);
        term_good        = tg_q && ramp_b_en && rail2_above_min;
        pgood            = ramp_b_en && (&rail_pg);
    end

    assert_b_after_rail2_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ramp_b_en) |-> $past(rail_pg[1]));
    assert_a_after_por_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ramp_a_en) |-> $past(por_ok));
    assert_tg_from_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(term_good) |-> $past(phase1_pulse));
    assert_inhibit_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_req |-> (!pgood && !term_good && rails123_inhibit));
endmodule

// File: rtl/rail_seq_top.sv
module rail_seq_top
    import rail_seq_pkg::*;
#(
    parameter int RAMP_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 por_ok,
    input  logic [NUM_RAILS-1:0] rail_pg,
    input  logic                 rail2_above_min,
    input  logic                 phase1_pulse,
    input  logic                 ramp_a_force_low,
    input  logic                 inhibit_req,
    input  logic [RAMP_W-1:0]    ramp_a_len,
    input  logic [RAMP_W-1:0]    ramp_b_len,
    output logic                 rail4_en,
    output logic                 ramp_a_en,
    output logic                 ramp_b_en,
    output logic                 ramp_a_up,
    output logic                 ramp_b_up,
    output logic                 rails123_inhibit,
    output logic                 term_good,
    output logic                 pgood
);
    logic              r4_q;
    logic [NUM_RAMPS-1:0] ramp_en;
    logic [NUM_RAMPS-1:0] ramp_up;
    logic [RAMP_W-1:0] ramp_len [NUM_RAMPS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r4_q <= 1'b0;
        else        r4_q <= 1'b1;
    end
    assign rail4_en = r4_q;

    seq_fsm u_fsm (
        .clk              (clk),
        .rst_n            (rst_n),
        .por_ok           (por_ok),
        .rail_pg          (rail_pg),
        .rail2_above_min  (rail2_above_min),
        .phase1_pulse     (phase1_pulse),
        .ramp_a_force_low (ramp_a_force_low),
        .inhibit_req      (inhibit_req),
        .ramp_a_en        (ramp_a_en),
        .ramp_b_en        (ramp_b_en),
        .rails123_inhibit (rails123_inhibit),
        .term_good        (term_good),
        .pgood            (pgood)
    );

    always_comb begin
        ramp_en[0]  = ramp_a_en;
        ramp_en[1]  = ramp_b_en;
        ramp_len[0] = ramp_a_len;
        ramp_len[1] = ramp_b_len;
    end

    for (genvar g = 0; g < NUM_RAMPS; g++) begin : g_ramp
        ss_ramp #(.CNT_W(RAMP_W)) u_ramp (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (ramp_en[g]),
            .len   (ramp_len[g]),
            .up    (ramp_up[g])
        );
    end

    assign ramp_a_up = ramp_up[0];
    assign ramp_b_up = ramp_up[1];

    assert_rail4_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rail4_en |=> rail4_en);
    assert_b_needs_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_b_up |-> ramp_a_en);
endmodule

// File: tb/sim_rail_seq_top.sv
module sim_rail_seq_top;
    localparam int W = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, por_ok, rail2_above_min, phase1_pulse, ramp_a_force_low, inhibit_req;
    logic [3:0]   rail_pg;
    logic [W-1:0] ramp_a_len, ramp_b_len;
    logic rail4_en, ramp_a_en, ramp_b_en, ramp_a_up, ramp_b_up, rails123_inhibit, term_good, pgood;

    rail_seq_top #(.RAMP_W(W)) u0 (.*);

    int checks = 0, fails = 0;
    int m_stage = 0;
    int m_ca = 0, m_cb = 0;
    bit m_tg = 0, m_r4 = 0;

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit f_stop();
        return inhibit_req || ramp_a_force_low || !por_ok;
    endfunction
    function automatic bit f_ea();
        return rst_n && (m_stage == 1 || m_stage == 2) && !f_stop();
    endfunction
    function automatic bit f_eb();
        return rst_n && (m_stage == 2) && !f_stop();
    endfunction

    task automatic check_all();
        bit ea, eb;
        ea = f_ea();
        eb = f_eb();
        chk("R1 rail4_en", rail4_en, m_r4);
        chk("R2 ramp_a_en", ramp_a_en, ea);
        chk("R3 ramp_b_en", ramp_b_en, eb);
        chk("R4 ramp_a_up", ramp_a_up, ea && (m_ca >= int'(ramp_a_len)));
        chk("R4 ramp_b_up", ramp_b_up, eb && (m_cb >= int'(ramp_b_len)));
        chk("R5,R6 term_good", term_good, m_tg && eb && rail2_above_min);
        chk("R7 pgood", pgood, eb && (&rail_pg));
        chk("R11 rails123_inhibit", rails123_inhibit, !ea);
    endtask

    task automatic model_update();
        bit ea, eb;
        ea = f_ea();
        eb = f_eb();
        if (!rst_n) begin
            m_stage = 0; m_ca = 0; m_cb = 0; m_tg = 0; m_r4 = 0;
        end else begin
            m_ca = ea ? ((m_ca < int'(ramp_a_len)) ? m_ca + 1 : m_ca) : 0;
            m_cb = eb ? ((m_cb < int'(ramp_b_len)) ? m_cb + 1 : m_cb) : 0;
            m_tg = eb && rail2_above_min && (m_tg || phase1_pulse);
            m_r4 = 1;
            if (!por_ok)                            m_stage = 0;
            else if (inhibit_req || ramp_a_force_low) m_stage = (m_stage == 0) ? 0 : 3;
            else if (m_stage == 0 || m_stage == 3)  m_stage = 1;
            else if (m_stage == 1 && rail_pg[1])    m_stage = 2;
        end
    endtask

    task automatic cyc();
        #2;
        check_all();
        model_update();
        @(negedge clk);
    endtask

    bit done = 0;
    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 0; por_ok = 0; rail_pg = '0; rail2_above_min = 0; phase1_pulse = 0;
        ramp_a_force_low = 0; inhibit_req = 0; ramp_a_len = 8'd4; ramp_b_len = 8'd3;
        @(negedge clk);
        cyc();
        // reset state, R1
        chk("R1 reset rail4_en", rail4_en, 1'b0);
        rst_n = 1;
        cyc();
        cyc();
        chk("R1 rail4 before POR", rail4_en, 1'b1);
        // nominal bring-up
        por_ok = 1; rail2_above_min = 1;
        phase1_pulse = 1; cyc();              // ignored: ramp B not released (R5)
        phase1_pulse = 0;
        for (int i = 0; i < 6; i++) cyc();
        chk("R4 ramp_a_up after len", ramp_a_up, 1'b1);
        rail_pg = 4'b0010; cyc();
        rail_pg = 4'b0000;
        cyc();
        chk("R5 no tg from early pulse", term_good, 1'b0);
        phase1_pulse = 1; cyc(); phase1_pulse = 0; cyc();
        chk("R5 tg set", term_good, 1'b1);
        rail2_above_min = 0; #2 chk("R6 tg drops same cycle", term_good, 1'b0);
        cyc(); rail2_above_min = 1; cyc(); cyc();
        chk("R6 tg needs new pulse", term_good, 1'b0);
        rail_pg = 4'b1111; #2 chk("R7 pgood", pgood, 1'b1);
        cyc();
        // forced low
        ramp_a_force_low = 1; #2;
        chk("R8 a_en low", ramp_a_en, 1'b0);
        chk("R8 pgood low", pgood, 1'b0);
        chk("R8 inhibit", rails123_inhibit, 1'b1);
        chk("R8 rail4 kept", rail4_en, 1'b1);
        cyc(); cyc(); ramp_a_force_low = 0; cyc();
        chk("R8 restart ramp A", ramp_a_en, 1'b1);
        chk("R8 count restarted", ramp_a_up, 1'b0);
        for (int i = 0; i < 3; i++) cyc();
        // inhibit
        inhibit_req = 1; #2;
        chk("R9 a_en low", ramp_a_en, 1'b0);
        chk("R9 b_en low", ramp_b_en, 1'b0);
        chk("R9 pgood low", pgood, 1'b0);
        cyc(); inhibit_req = 0; cyc(); cyc();
        // POR drop
        por_ok = 0; cyc(); por_ok = 0; #2;
        chk("R10 a_en", ramp_a_en, 1'b0);
        chk("R10 term_good", term_good, 1'b0);
        chk("R10 rail4", rail4_en, 1'b1);
        cyc();
        // zero-length ramps
        ramp_a_len = 0; ramp_b_len = 0; por_ok = 1; cyc();
        chk("R4 zero length up", ramp_a_up, 1'b1);
        for (int i = 0; i < 4; i++) cyc();
        // constrained random
        for (int n = 0; n < 6000; n++) begin
            por_ok           = ($urandom % 100) >= 2;
            ramp_a_force_low = ($urandom % 100) < 2;
            inhibit_req      = ($urandom % 100) < 2;
            rail2_above_min  = ($urandom % 100) < 92;
            phase1_pulse     = ($urandom % 100) < 15;
            rail_pg          = 4'($urandom);
            rail_pg[1]       = ($urandom % 100) < 30;
            if ($urandom % 50 == 0) begin
                ramp_a_len = W'($urandom % 8);
                ramp_b_len = W'($urandom % 8);
            end
            if (($urandom % 20) < 15) rail_pg = rail_pg | 4'b1101;
            cyc();
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule